// File: doc/BRIEF.md
# Programmable Vertical Sync Generator

This block produces two vertical sync outputs, one for a CRT and one for a flat panel, from a single vertical position counter. A line strobe from the pixel-clock domain arrives once per horizontal line. The counter advances on each strobe, wraps at a programmed total, and is forced back to zero by a frame reset input. In interlaced mode the counter also advances at the middle of each line. The block finds the middle by timing the distance between successive strobes. With an odd total, the sync edge therefore falls mid-line in one field and at a line boundary in the next.

Software sets the sync windows through a small write port. Both outputs use the same field layout. The CRT fields hold the target line minus one. The panel fields hold the target line minus two. The panel sync is generated internally and then captured on each rising edge of the panel horizontal sync input before it reaches the panel. The window and total registers accept writes only while an unlock bit is set.

Top module: `vsync_gen`

## Requirements
- R1: Register select 0 holds the CRT window and select 1 the panel window, each with the stop value in bits 26:16 and the start value in bits 10:0. All other bits read as zero. Select 2 holds the vertical total in bits 10:0. Select 3 holds the unlock bit in bit 0. Reads are combinational from `rd_addr`.
- R2: A write to select 0, 1 or 2 is ignored while the unlock bit is 0. Select 3 is always writable, and reads always return the stored value.
- R3: In progressive mode the counter advances by one on each cycle with `line_stb` high. From `total-1` it returns to 0, and a total of 0 holds it at 0. `frame_rst` sets the counter to 0 and clears both internal sync windows on the next clock.
- R4: `crt_vs` is active-high. It rises one clock after the counter reaches start+1 and falls one clock after the counter reaches stop+1, using 11-bit wraparound.
- R5: The internal panel window rises one clock after the counter reaches start+2 and falls one clock after it reaches stop+2.
- R6: `pnl_vs` takes the internal panel window value only at a clock where `pnl_hs` is high and was low in the previous cycle. At every other clock it holds its value.
- R7: A window whose start equals its stop never asserts its sync.
- R8: When `interlace` is 1, the counter also advances in the cycle when the clock count since the last strobe equals half (rounded down) of the last measured strobe-to-strobe distance. The cycle with the strobe is count 0, and no mid-line advance happens before a distance has been measured.
- R9: After reset, both outputs are 0, all registers read 0, and the block is locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 2 | Register select for writes |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Register select for reads |
| rd_data | output | 32 | Read data |
| line_stb | input | 1 | One-cycle pulse per horizontal line |
| interlace | input | 1 | 1 = counter advances twice per line |
| frame_rst | input | 1 | Forces the counter to zero |
| pnl_hs | input | 1 | Panel horizontal sync, captures panel sync on its rising edge |
| crt_vs | output | 1 | CRT vertical sync, active-high |
| pnl_vs | output | 1 | Panel vertical sync, active-high |

## Verification
The hardest case to reach is the alternation of the CRT sync edge between mid-line and line boundary in interlaced mode. It needs a measured line length, an odd total and a known starting phase all at once. The stimulus first runs several interlaced lines of fixed length so the strobe distance is known. It then pulses the frame reset in the last cycle before a strobe and records the cycle offset of each CRT rising edge within its line, expecting a mid-line offset followed by a line-start offset. Panel sync holding without horizontal sync edges is reached by suppressing `pnl_hs` for lines in which the internal window changes.

// File: rtl/vsync_pkg.sv
package vsync_pkg;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned HI_LSB  = 16;
  localparam int unsigned NUM_WIN = 2;

  typedef enum logic [1:0] {
    SEL_CRT = 2'd0,
    SEL_PNL = 2'd1,
    SEL_TOT = 2'd2,
    SEL_CTL = 2'd3
  } vs_sel_e;
endpackage

// File: rtl/vsync_regs.sv
module vsync_regs
  import vsync_pkg::*;
#(
  parameter int unsigned CNT_W = 11
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [1:0]                       wr_addr,
  input  logic [REG_W-1:0]                 wr_data,
  input  logic [1:0]                       rd_addr,
  output logic [REG_W-1:0]                 rd_data,
  output logic [NUM_WIN-1:0][CNT_W-1:0]    win_start,
  output logic [NUM_WIN-1:0][CNT_W-1:0]    win_stop,
  output logic [CNT_W-1:0]                 total,
  output logic                             unlock
);
  logic             unused_rsvd;
  logic             unl_q, unl_d;
  logic [CNT_W-1:0] tot_q, tot_d;
  logic             tot_we, ctl_we;

  assign unused_rsvd = ^wr_data;
  assign ctl_we = wr_en && (wr_addr == SEL_CTL);
  assign tot_we = wr_en && unl_q && (wr_addr == SEL_TOT);

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    localparam logic [1:0] MY_SEL = 2'(w);
    logic [CNT_W-1:0] s_q, s_d, e_q, e_d;
    logic             we;

    assign we = wr_en && unl_q && (wr_addr == MY_SEL);

    always_comb begin
      s_d = s_q;
      e_d = e_q;
      if (we) begin
        s_d = wr_data[CNT_W-1:0];
        e_d = wr_data[HI_LSB +: CNT_W];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s_q <= '0;
        e_q <= '0;
      end else begin
        s_q <= s_d;
        e_q <= e_d;
      end
    end

    assign win_start[w] = s_q;
    assign win_stop[w]  = e_q;
  end

  always_comb begin
    unl_d = unl_q;
    tot_d = tot_q;
    if (ctl_we) unl_d = wr_data[0];
    if (tot_we) tot_d = wr_data[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unl_q <= 1'b0;
      tot_q <= '0;
    end else begin
      unl_q <= unl_d;
      tot_q <= tot_d;
    end
  end

  function automatic logic [REG_W-1:0] pack_win(input logic [CNT_W-1:0] hi,
                                                 input logic [CNT_W-1:0] lo);
    logic [REG_W-1:0] r;
    r = '0;
    r[HI_LSB +: CNT_W] = hi;
    r[CNT_W-1:0]       = lo;
    return r;
  endfunction

  always_comb begin
    rd_data = '0;
    case (vs_sel_e'(rd_addr))
      SEL_CRT: rd_data = pack_win(win_stop[0], win_start[0]);
      SEL_PNL: rd_data = pack_win(win_stop[1], win_start[1]);
      SEL_TOT: rd_data[CNT_W-1:0] = tot_q;
      SEL_CTL: rd_data[0] = unl_q;
      default: rd_data = '0;
    endcase
  end

  assign total  = tot_q;
  assign unlock = unl_q;
endmodule

// File: rtl/vsync_halfline.sv
module vsync_halfline #(
  parameter int unsigned LEN_W = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_stb,
  output logic mid_stb
);
  localparam logic [LEN_W-1:0] LEN_MAX = '1;

  logic [LEN_W-1:0] cyc_q, cyc_d;
  logic [LEN_W-1:0] per_q, per_d;

  always_comb begin
    cyc_d = cyc_q;
    per_d = per_q;
    if (line_stb) begin
      per_d = cyc_q;
      cyc_d = LEN_W'(1);
    end else if (cyc_q != LEN_MAX) begin
      cyc_d = cyc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q <= '0;
      per_q <= '0;
    end else begin
      cyc_q <= cyc_d;
      per_q <= per_d;
    end
  end

  assign mid_stb = !line_stb && (per_q != '0) && (cyc_q == (per_q >> 1));
endmodule

// File: rtl/vsync_counter.sv
module vsync_counter #(
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             frame_rst,
  input  logic [CNT_W-1:0] total,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   nxt_wide;

  assign nxt_wide = {1'b0, cnt_q} + 1'b1;

  always_comb begin
    cnt_d = cnt_q;
    if (frame_rst) begin
      cnt_d = '0;
    end else if (tick) begin
      cnt_d = (nxt_wide >= {1'b0, total}) ? '0 : nxt_wide[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/vsync_window.sv
module vsync_window #(
  parameter int unsigned CNT_W  = 11,
  parameter int unsigned OFFSET = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_rst,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] start,
  input  logic [CNT_W-1:0] stop,
  output logic             win
);
  logic [CNT_W-1:0] on_at, off_at;
  logic             win_q, win_d;

  assign on_at  = start + CNT_W'(OFFSET);
  assign off_at = stop  + CNT_W'(OFFSET);

  always_comb begin
    win_d = win_q;
    if (frame_rst)          win_d = 1'b0;
    else if (cnt == off_at) win_d = 1'b0;
    else if (cnt == on_at)  win_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_q <= 1'b0;
    else        win_q <= win_d;
  end

  assign win = win_q;
endmodule

// File: rtl/vsync_gen.sv
module vsync_gen
  import vsync_pkg::*;
#(
  parameter int unsigned CNT_W = 11,
  parameter int unsigned LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [REG_W-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [REG_W-1:0] rd_data,
  input  logic             line_stb,
  input  logic             interlace,
  input  logic             frame_rst,
  input  logic             pnl_hs,
  output logic             crt_vs,
  output logic             pnl_vs
);
  logic [NUM_WIN-1:0][CNT_W-1:0] win_start, win_stop;
  logic [CNT_W-1:0]              total, cnt;
  logic                          unlock, mid_stb, tick;
  logic [NUM_WIN-1:0]            win_raw;
  logic                          hs_d_q, hs_rise;
  logic                          pnl_q, pnl_d;

  vsync_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .win_start(win_start), .win_stop(win_stop), .total(total), .unlock(unlock)
  );

  vsync_halfline #(.LEN_W(LEN_W)) u_half (
    .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .mid_stb(mid_stb)
  );

  assign tick = line_stb | (interlace & mid_stb);

  vsync_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .frame_rst(frame_rst),
    .total(total), .cnt(cnt)
  );

  // window 0 drives the CRT (offset 1), window 1 the panel (offset 2)
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    vsync_window #(.CNT_W(CNT_W), .OFFSET(w + 1)) u_win (
      .clk(clk), .rst_n(rst_n), .frame_rst(frame_rst), .cnt(cnt),
      .start(win_start[w]), .stop(win_stop[w]), .win(win_raw[w])
    );
  end

  assign hs_rise = pnl_hs & ~hs_d_q;

  always_comb begin
    pnl_d = pnl_q;
    if (hs_rise) pnl_d = win_raw[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_d_q <= 1'b0;
      pnl_q  <= 1'b0;
    end else begin
      hs_d_q <= pnl_hs;
      pnl_q  <= pnl_d;
    end
  end

  assign crt_vs = win_raw[0];
  assign pnl_vs = pnl_q;
endmodule

// File: rtl/vsync_gen_chk.sv
module vsync_gen_chk
  import vsync_pkg::*;
#(
  parameter int unsigned CNT_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       wr_addr,
  input logic             unlock,
  input logic [CNT_W-1:0] crt_start,
  input logic [CNT_W-1:0] crt_end,
  input logic [CNT_W-1:0] total,
  input logic [CNT_W-1:0] cnt,
  input logic             crt_vs,
  input logic             pnl_vs,
  input logic             hs_rise,
  input logic             frame_rst,
  input logic             line_stb,
  input logic             mid_stb,
  input logic             interlace,
  input logic [1:0]       rd_addr,
  input logic [REG_W-1:0] rd_data
);
  localparam logic [REG_W-1:0] LO_MASK    = REG_W'((64'd1 << CNT_W) - 64'd1);
  localparam logic [REG_W-1:0] FIELD_MASK = LO_MASK | (LO_MASK << HI_LSB);

  logic [CNT_W-1:0] crt_on;
  assign crt_on = crt_start + 1'b1;

  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == SEL_CRT || rd_addr == SEL_PNL) |-> ((rd_data & ~FIELD_MASK) == '0));

  a_r2_locked_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !unlock && wr_addr != SEL_CTL)
      |=> ($stable(crt_start) && $stable(crt_end) && $stable(total)));

  a_r3_frame_clear: assert property (@(posedge clk) disable iff (!rst_n)
    frame_rst |=> (cnt == '0) && !crt_vs);

  a_r3_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_stb && !(interlace && mid_stb) && !frame_rst) |=> $stable(cnt));

  a_r4_rise_line: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crt_vs) |-> ($past(cnt) == $past(crt_on)));

  a_r7_empty_window: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crt_vs) |-> $past(crt_start != crt_end));

  a_r6_panel_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    !hs_rise |=> $stable(pnl_vs));
endmodule

bind vsync_gen vsync_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .unlock(unlock),
  .crt_start(win_start[0]), .crt_end(win_stop[0]), .total(total), .cnt(cnt),
  .crt_vs(crt_vs), .pnl_vs(pnl_vs), .hs_rise(hs_rise), .frame_rst(frame_rst),
  .line_stb(line_stb), .mid_stb(mid_stb), .interlace(interlace),
  .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/sim_vsync_gen.sv
module sim_vsync_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        line_stb = 1'b0, interlace = 1'b0, frame_rst = 1'b0, pnl_hs = 1'b0;
  logic        crt_vs, pnl_vs;

  always #10 clk = ~clk;

  vsync_gen u0 (.*);

  int n_chk = 0, n_err = 0;
  bit done = 0;

  task automatic check(string tag, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_cyc, m_per, m_cnt, m_crt, m_pint, m_pnl, m_hsd, m_tot, m_unl;
  int m_s[2], m_e[2];
  int ofs;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cyc = 0; m_per = 0; m_cnt = 0; m_crt = 0; m_pint = 0; m_pnl = 0;
      m_hsd = 0; m_tot = 0; m_unl = 0; m_s = '{0, 0}; m_e = '{0, 0}; ofs = 0;
    end else begin
      bit mid, tk;
      int n_cnt, n_crt, n_pint, n_pnl;
      mid = !line_stb && m_per != 0 && m_cyc == m_per / 2;
      tk  = line_stb || (interlace && mid);
      if (frame_rst) n_cnt = 0;
      else if (tk) n_cnt = (m_cnt + 1 >= m_tot) ? 0 : m_cnt + 1;
      else n_cnt = m_cnt;
      if (frame_rst) n_crt = 0;
      else if (m_cnt == (m_e[0] + 1) % 2048) n_crt = 0;
      else if (m_cnt == (m_s[0] + 1) % 2048) n_crt = 1;
      else n_crt = m_crt;
      if (frame_rst) n_pint = 0;
      else if (m_cnt == (m_e[1] + 2) % 2048) n_pint = 0;
      else if (m_cnt == (m_s[1] + 2) % 2048) n_pint = 1;
      else n_pint = m_pint;
      n_pnl = (pnl_hs && !m_hsd) ? m_pint : m_pnl;
      if (line_stb) begin m_per = m_cyc; m_cyc = 1; end
      else if (m_cyc < 4095) m_cyc++;
      if (wr_en) begin
        if (wr_addr == 2'd3) m_unl = int'(wr_data[0]);
        else if (m_unl != 0) begin
          if (wr_addr == 2'd2) m_tot = int'(wr_data[10:0]);
          else begin
            m_s[wr_addr] = int'(wr_data[10:0]);
            m_e[wr_addr] = int'(wr_data[26:16]);
          end
        end
      end
      ofs = line_stb ? 1 : ofs + 1;
      m_hsd = int'(pnl_hs);
      m_cnt = n_cnt; m_crt = n_crt; m_pint = n_pint; m_pnl = n_pnl;
    end
  end

  // per-clock comparison and CRT rise-offset recording
  int rise_q[$];
  logic prev_crt = 1'b0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R4", "crt model", crt_vs, m_crt);
      check("R6", "panel model", pnl_vs, m_pnl);
      if (crt_vs && !prev_crt) rise_q.push_back(ofs);
      prev_crt = crt_vs;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); rd_addr = a; #1 d = rd_data;
  endtask

  function automatic logic [31:0] win_word(int s, int e, bit junk);
    logic [31:0] w;
    w = junk ? 32'hF800_F800 : 32'h0;
    w[10:0] = 11'(s); w[26:16] = 11'(e);
    return w;
  endfunction

  task automatic run_line(int len, bit hs_en);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      line_stb = (k == 0);
      pnl_hs   = hs_en && (k >= 5) && (k <= 7);
    end
  endtask

  task automatic pulse_frame_rst();
    @(negedge clk); line_stb = 1'b0; pnl_hs = 1'b0; frame_rst = 1'b1;
    @(negedge clk); frame_rst = 1'b0;
  endtask

  // ---------------- main sequence ----------------
  initial begin
    logic [31:0] d;
    int hi_crt, hi_pnl;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9 reset state
    check("R9", "crt_vs after reset", crt_vs, 0);
    check("R9", "pnl_vs after reset", pnl_vs, 0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d); check("R9", "register after reset", d, 0);
    end

    // R2 locked writes ignored
    wr(2'd0, win_word(7, 9, 0));
    wr(2'd2, 32'd33);
    rd(2'd0, d); check("R2", "crt window locked", d, 0);
    rd(2'd2, d); check("R2", "total locked", d, 0);

    // R1 layout and reserved bits
    wr(2'd3, 32'd1);
    rd(2'd3, d); check("R1", "unlock bit", d, 1);
    wr(2'd0, win_word(2, 5, 1));
    wr(2'd1, win_word(2, 5, 1));
    wr(2'd2, 32'hFFFF_F800 | 32'd10);
    rd(2'd0, d); check("R1", "crt readback", d, 32'h0005_0002);
    rd(2'd1, d); check("R1", "panel readback", d, 32'h0005_0002);
    rd(2'd2, d); check("R1", "total readback", d, 10);

    // R3/R4/R5 progressive frames: crt on cnt 3..5, panel on cnt 4..6
    run_line(20, 1);
    pulse_frame_rst();
    check("R3", "crt cleared by frame reset", crt_vs, 0);
    for (int i = 1; i <= 25; i++) begin
      int c;
      run_line(20, 1);
      c = i % 10;
      check("R4", $sformatf("crt at count %0d", c), crt_vs, (c >= 3 && c < 6));
      check("R5", $sformatf("panel at count %0d", c), pnl_vs, (c >= 4 && c < 7));
    end

    // R6 panel holds without a horizontal sync edge (last count 5 -> panel 1)
    pulse_frame_rst();
    run_line(20, 0);
    run_line(20, 0);
    check("R6", "panel held without hs edge", pnl_vs, 1);
    run_line(20, 1);
    check("R6", "panel updated on hs edge", pnl_vs, 0);

    // R2 relock and ignored write
    wr(2'd3, 32'd0);
    wr(2'd0, win_word(1, 1, 0));
    rd(2'd0, d); check("R2", "crt window after relock", d, 32'h0005_0002);

    // R7 empty windows
    wr(2'd3, 32'd1);
    wr(2'd0, win_word(3, 3, 0));
    wr(2'd1, win_word(3, 3, 0));
    pulse_frame_rst();
    hi_crt = 0; hi_pnl = 0;
    for (int i = 0; i < 24; i++) begin
      run_line(20, 1);
      hi_crt += int'(crt_vs); hi_pnl += int'(pnl_vs);
    end
    check("R7", "crt highs with start==stop", hi_crt, 0);
    check("R7", "panel highs with start==stop", hi_pnl, 0);

    // R8 interlace, odd total 9, crt on count 4..5
    wr(2'd2, 32'd9);
    wr(2'd0, win_word(3, 5, 0));
    wr(2'd1, win_word(3, 5, 0));
    interlace = 1'b1;
    for (int i = 0; i < 3; i++) run_line(20, 1);
    pulse_frame_rst();
    rise_q.delete();
    for (int i = 0; i < 18; i++) run_line(20, 1);
    check("R8", "crt rises recorded", (rise_q.size() >= 2), 1);
    if (rise_q.size() >= 2) begin
      check("R8", "first field rise offset (mid-line)", rise_q[0], 12);
      check("R8", "second field rise offset (line start)", rise_q[1], 2);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule